// File: doc/BRIEF.md
# Ping-pong buffered transfer scheduler

This block orders the phases of a batch job that moves data from a host into local storage, processes it and sends the results back. It owns two data buffers. Each iteration fills one buffer over the host channel, runs one compute pass over it and drains the results over the same channel. The block drives a transfer engine and a compute engine with one-cycle start pulses and waits for their one-cycle done pulses. It does not see the data, the bus protocol or the kernel.

A mode bit, sampled when a run starts, picks the schedule. In serial mode every phase of every iteration runs alone on buffer 0. In ping-pong mode the iterations alternate between the two buffers, so channel traffic on one buffer overlaps compute on the other. The steady-state cost per iteration then falls to the larger of the channel time and the compute time. Three cycle counters record channel-busy, compute-busy and total run time, so that utilization can be worked out after the run.

Top module: `pingpong_sched`

## Requirements
- R1: After reset, busy_o, done_o, xfer_start_o and comp_start_o are low and all three cycle counters read zero.
- R2: A start_i pulse while idle latches iter_cnt_i and mode_dbl_i (1 = ping-pong, 0 = serial), raises busy_o in the next cycle and clears all three counters.
- R3: In serial mode, iteration k runs read, compute and write on buffer 0 strictly in that order, and the next read follows the previous write's done. Each phase starts in the cycle after the previous done, so one iteration takes Lr+Lc+Lw+3 cycles.
- R4: In ping-pong mode, iteration i (counting from 1) uses buffer (i-1) mod 2. The channel order is R1, R2, W1, R3, W2, R4, W3 and so on, and compute passes run in iteration order on alternating buffers. xfer_wr_o is 1 for a write and 0 for a read.
- R5: The channel carries one transfer at a time and the compute engine runs one pass at a time: no start is issued while the previous done of that engine is outstanding.
- R6: A buffer is never computed on while the channel is moving it, and it is never moved while it is being computed on.
- R7: The first compute pass of a run starts only after the first read has completed.
- R8: With two or more iterations, ping-pong mode keeps the channel and the compute engine busy in the same cycle. Its total run time is below the serial time and no less than N times the larger of (Lr+Lw) and Lc.
- R9: chan_cycles_o counts cycles with a transfer outstanding (N*(Lr+Lw) per run) and comp_cycles_o counts cycles with a pass outstanding (N*Lc). total_cycles_o counts the cycles busy_o is high. All three hold their values after the run ends.
- R10: done_o pulses for exactly one cycle, in the cycle after the final write's done, with busy_o already low.
- R11: A start_i pulse while busy_o is high is ignored: the iteration count, mode and counters of the running job are unchanged.
- R12: A start with an iteration count of zero issues no transfer or compute and pulses done_o in the next cycle, with counters at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| mode_dbl_i | input | 1 | 1 = ping-pong over two buffers, 0 = serial on buffer 0 |
| iter_cnt_i | input | IW | Number of iterations for the run |
| xfer_start_o | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_wr_o | output | 1 | Transfer direction, 1 = write-back, 0 = read |
| xfer_buf_o | output | 1 | Buffer index for the transfer |
| xfer_done_i | input | 1 | One-cycle completion pulse from the transfer engine |
| comp_start_o | output | 1 | One-cycle start pulse to the compute engine |
| comp_buf_o | output | 1 | Buffer index for the compute pass |
| comp_done_i | input | 1 | One-cycle completion pulse from the compute engine |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle run-complete pulse |
| chan_cycles_o | output | CW | Channel-busy cycle count |
| comp_cycles_o | output | CW | Compute-busy cycle count |
| total_cycles_o | output | CW | Total run cycle count |

## Verification
The schedule is tried with serial runs, a single-iteration ping-pong run, a compute-bound ping-pong run, a channel-bound ping-pong run and back-to-back runs with one-cycle engines. The serial runs pin down exact cycle counts. The single ping-pong iteration must match the serial timing. The compute-bound and channel-bound cases show that the channel order stays the same whichever side hides the other. The minimal-latency cases expose off-by-one slips in the handshake turnaround. A start pulse in the middle of a run, a zero-length run and a second run after a first (for the counter clear) cover the control corners.

// File: rtl/pingpong_sched_pkg.sv
package pingpong_sched_pkg;
  localparam int NUM_SLOTS = 2;
  localparam int NUM_CTRS  = 3;

  typedef enum logic [2:0] {
    SLOT_EMPTY,
    SLOT_FILL,
    SLOT_LOADED,
    SLOT_CALC,
    SLOT_RESULT,
    SLOT_DRAIN
  } slot_st_e;
endpackage

// File: rtl/pingpong_slot.sv
module pingpong_slot
  import pingpong_sched_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     fill_go_i,
  input  logic     fill_fin_i,
  input  logic     calc_go_i,
  input  logic     calc_fin_i,
  input  logic     drain_go_i,
  input  logic     drain_fin_i,
  output slot_st_e st_o
);
  slot_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SLOT_EMPTY;
    else if (clr_i) st_q <= SLOT_EMPTY;
    else begin
      unique case (st_q)
        SLOT_EMPTY:  if (fill_go_i)   st_q <= SLOT_FILL;
        SLOT_FILL:   if (fill_fin_i)  st_q <= SLOT_LOADED;
        SLOT_LOADED: if (calc_go_i)   st_q <= SLOT_CALC;
        SLOT_CALC:   if (calc_fin_i)  st_q <= SLOT_RESULT;
        SLOT_RESULT: if (drain_go_i)  st_q <= SLOT_DRAIN;
        SLOT_DRAIN:  if (drain_fin_i) st_q <= SLOT_EMPTY;
        default:                      st_q <= SLOT_EMPTY;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/pingpong_issue.sv
module pingpong_issue
  import pingpong_sched_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic                      run_i,
  input  logic                      dbl_i,
  input  logic                      chan_busy_i,
  input  logic                      comp_busy_i,
  input  logic [IW-1:0]             iter_i,
  input  logic [IW-1:0]             rd_cnt_i,
  input  logic [IW-1:0]             cp_cnt_i,
  input  logic [IW-1:0]             wr_cnt_i,
  input  slot_st_e [NUM_SLOTS-1:0]  st_i,
  output logic                      rd_go_o,
  output logic                      wr_go_o,
  output logic                      cp_go_o,
  output logic                      rd_buf_o,
  output logic                      wr_buf_o,
  output logic                      cp_buf_o
);
  // serial mode pins every phase to slot 0, which serializes by itself
  assign rd_buf_o = dbl_i & rd_cnt_i[0];
  assign wr_buf_o = dbl_i & wr_cnt_i[0];
  assign cp_buf_o = dbl_i & cp_cnt_i[0];

  // reads win the channel over write-back
  assign rd_go_o = run_i && !chan_busy_i && (rd_cnt_i != iter_i) &&
                   (st_i[rd_buf_o] == SLOT_EMPTY);
  assign wr_go_o = run_i && !chan_busy_i && !rd_go_o && (wr_cnt_i != iter_i) &&
                   (st_i[wr_buf_o] == SLOT_RESULT);
  assign cp_go_o = run_i && !comp_busy_i && (cp_cnt_i != iter_i) &&
                   (st_i[cp_buf_o] == SLOT_LOADED);
endmodule

// File: rtl/pingpong_busy_ctr.sv
module pingpong_busy_ctr #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pingpong_sched.sv
module pingpong_sched
  import pingpong_sched_pkg::*;
#(
  parameter int IW = 16,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_dbl_i,
  input  logic [IW-1:0] iter_cnt_i,
  output logic          xfer_start_o,
  output logic          xfer_wr_o,
  output logic          xfer_buf_o,
  input  logic          xfer_done_i,
  output logic          comp_start_o,
  output logic          comp_buf_o,
  input  logic          comp_done_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] chan_cycles_o,
  output logic [CW-1:0] comp_cycles_o,
  output logic [CW-1:0] total_cycles_o
);
  logic          run_q, dbl_q, done_q;
  logic [IW-1:0] iter_q, rd_cnt_q, cp_cnt_q, wr_cnt_q;
  logic          chan_busy_q, chan_wr_q, chan_buf_q;
  logic          comp_busy_q, comp_buf_q;

  logic rd_go, wr_go, cp_go, rd_buf, wr_buf, cp_buf;
  logic start_acc, chan_fin, comp_fin, last_wr;
  slot_st_e [NUM_SLOTS-1:0] slot_st;

  assign start_acc = start_i && !run_q;
  assign chan_fin  = xfer_done_i && chan_busy_q;
  assign comp_fin  = comp_done_i && comp_busy_q;
  assign last_wr   = chan_fin && chan_wr_q && (wr_cnt_q == iter_q);

  pingpong_issue #(.IW(IW)) u_issue (
    .run_i       (run_q),
    .dbl_i       (dbl_q),
    .chan_busy_i (chan_busy_q),
    .comp_busy_i (comp_busy_q),
    .iter_i      (iter_q),
    .rd_cnt_i    (rd_cnt_q),
    .cp_cnt_i    (cp_cnt_q),
    .wr_cnt_i    (wr_cnt_q),
    .st_i        (slot_st),
    .rd_go_o     (rd_go),
    .wr_go_o     (wr_go),
    .cp_go_o     (cp_go),
    .rd_buf_o    (rd_buf),
    .wr_buf_o    (wr_buf),
    .cp_buf_o    (cp_buf)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    pingpong_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (start_acc),
      .fill_go_i   (rd_go && (rd_buf == g[0])),
      .fill_fin_i  (chan_fin && !chan_wr_q && (chan_buf_q == g[0])),
      .calc_go_i   (cp_go && (cp_buf == g[0])),
      .calc_fin_i  (comp_fin && (comp_buf_q == g[0])),
      .drain_go_i  (wr_go && (wr_buf == g[0])),
      .drain_fin_i (chan_fin && chan_wr_q && (chan_buf_q == g[0])),
      .st_o        (slot_st[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      dbl_q       <= 1'b0;
      done_q      <= 1'b0;
      iter_q      <= '0;
      rd_cnt_q    <= '0;
      cp_cnt_q    <= '0;
      wr_cnt_q    <= '0;
      chan_busy_q <= 1'b0;
      chan_wr_q   <= 1'b0;
      chan_buf_q  <= 1'b0;
      comp_busy_q <= 1'b0;
      comp_buf_q  <= 1'b0;
    end else if (start_acc) begin
      run_q       <= (iter_cnt_i != '0);
      dbl_q       <= mode_dbl_i;
      done_q      <= (iter_cnt_i == '0);
      iter_q      <= iter_cnt_i;
      rd_cnt_q    <= '0;
      cp_cnt_q    <= '0;
      wr_cnt_q    <= '0;
      chan_busy_q <= 1'b0;
      comp_busy_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rd_go || wr_go) begin
        chan_busy_q <= 1'b1;
        chan_wr_q   <= wr_go;
        chan_buf_q  <= wr_go ? wr_buf : rd_buf;
      end else if (chan_fin) begin
        chan_busy_q <= 1'b0;
      end
      if (cp_go) begin
        comp_busy_q <= 1'b1;
        comp_buf_q  <= cp_buf;
      end else if (comp_fin) begin
        comp_busy_q <= 1'b0;
      end
      if (rd_go) rd_cnt_q <= rd_cnt_q + 1'b1;
      if (wr_go) wr_cnt_q <= wr_cnt_q + 1'b1;
      if (cp_go) cp_cnt_q <= cp_cnt_q + 1'b1;
      if (last_wr) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  logic [NUM_CTRS-1:0]         ctr_inc;
  logic [NUM_CTRS-1:0][CW-1:0] ctr_val;
  assign ctr_inc = {run_q, comp_busy_q, chan_busy_q};

  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
    pingpong_busy_ctr #(.CW(CW)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_acc),
      .inc_i  (ctr_inc[c]),
      .cnt_o  (ctr_val[c])
    );
  end

  assign chan_cycles_o  = ctr_val[0];
  assign comp_cycles_o  = ctr_val[1];
  assign total_cycles_o = ctr_val[2];

  assign xfer_start_o = rd_go || wr_go;
  assign xfer_wr_o    = wr_go;
  assign xfer_buf_o   = wr_go ? wr_buf : rd_buf;
  assign comp_start_o = cp_go;
  assign comp_buf_o   = cp_buf;
  assign busy_o       = run_q;
  assign done_o       = done_q;
endmodule

// File: rtl/pingpong_sched_chk.sv
module pingpong_sched_chk #(
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mode_dbl_i,
  input logic          xfer_start_o,
  input logic          xfer_wr_o,
  input logic          xfer_buf_o,
  input logic          xfer_done_i,
  input logic          comp_start_o,
  input logic          comp_buf_o,
  input logic          comp_done_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] chan_cycles_o,
  input logic [CW-1:0] comp_cycles_o,
  input logic [CW-1:0] total_cycles_o
);
  logic ch_act, ch_wr, ch_buf, cp_act, cp_buf, sb_q, rd_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_act <= 1'b0; ch_wr <= 1'b0; ch_buf <= 1'b0;
      cp_act <= 1'b0; cp_buf <= 1'b0; sb_q <= 1'b0; rd_seen <= 1'b0;
    end else begin
      if (xfer_start_o) begin
        ch_act <= 1'b1; ch_wr <= xfer_wr_o; ch_buf <= xfer_buf_o;
      end else if (xfer_done_i) ch_act <= 1'b0;
      if (comp_start_o) begin
        cp_act <= 1'b1; cp_buf <= comp_buf_o;
      end else if (comp_done_i) cp_act <= 1'b0;
      if (start_i && !busy_o) begin
        sb_q    <= !mode_dbl_i;
        rd_seen <= 1'b0;
      end else if (xfer_done_i && ch_act && !ch_wr) rd_seen <= 1'b1;
    end
  end

  assert_chan_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> !ch_act);
  assert_comp_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_start_o |-> !cp_act);
  assert_serial_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_q && cp_act) |-> !ch_act);
  assert_calc_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_start_o && ch_act) |-> (comp_buf_o != ch_buf));
  assert_move_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_o && cp_act) |-> (xfer_buf_o != cp_buf));
  assert_first_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_start_o |-> rd_seen);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !xfer_done_i) |=> busy_o);
  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(chan_cycles_o) && $stable(comp_cycles_o) &&
                               $stable(total_cycles_o)));
endmodule

bind pingpong_sched pingpong_sched_chk #(.CW(CW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .mode_dbl_i     (mode_dbl_i),
  .xfer_start_o   (xfer_start_o),
  .xfer_wr_o      (xfer_wr_o),
  .xfer_buf_o     (xfer_buf_o),
  .xfer_done_i    (xfer_done_i),
  .comp_start_o   (comp_start_o),
  .comp_buf_o     (comp_buf_o),
  .comp_done_i    (comp_done_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .chan_cycles_o  (chan_cycles_o),
  .comp_cycles_o  (comp_cycles_o),
  .total_cycles_o (total_cycles_o)
);

// File: tb/pingpong_sched_bench.sv
module pingpong_sched_bench;
  localparam int IW = 16;
  localparam int CW = 32;
  localparam int NROWS = 6;
  localparam int LOGN = 64;
  // mode, iterations, read latency, compute latency, write latency
  localparam int TBL [NROWS][5] = '{
    '{0, 3, 2, 3, 2},
    '{1, 1, 2, 3, 2},
    '{1, 5, 2, 8, 2},
    '{1, 5, 4, 2, 5},
    '{0, 4, 1, 1, 1},
    '{1, 6, 1, 1, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [IW-1:0] iters = '0;
  logic xfer_start, xfer_wr, xfer_buf, xfer_done;
  logic comp_start, comp_buf, comp_done;
  logic busy, done;
  logic [CW-1:0] chan_cyc, comp_cyc, tot_cyc;

  always #2 clk = ~clk;

  pingpong_sched #(.IW(IW), .CW(CW)) u_pingpong_sched (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_dbl_i(mode),
    .iter_cnt_i(iters), .xfer_start_o(xfer_start), .xfer_wr_o(xfer_wr),
    .xfer_buf_o(xfer_buf), .xfer_done_i(xfer_done), .comp_start_o(comp_start),
    .comp_buf_o(comp_buf), .comp_done_i(comp_done), .busy_o(busy), .done_o(done),
    .chan_cycles_o(chan_cyc), .comp_cycles_o(comp_cyc), .total_cycles_o(tot_cyc)
  );

  int lat_r = 1, lat_c = 1, lat_w = 1;
  int ch_cnt = 0, cp_cnt = 0;
  int ch_n = 0, cp_n = 0;
  logic [1:0] ch_log [LOGN];
  logic       cp_log [LOGN];
  logic log_clr = 1'b0;
  logic overlap = 1'b0;

  assign xfer_done = (ch_cnt == 1);
  assign comp_done = (cp_cnt == 1);

  // engine models with fixed latency, plus issue logs
  always @(posedge clk) begin
    if (xfer_start) begin
      ch_cnt <= xfer_wr ? lat_w : lat_r;
      if (ch_n < LOGN) ch_log[ch_n] <= {xfer_wr, xfer_buf};
      ch_n <= ch_n + 1;
    end else if (ch_cnt != 0) ch_cnt <= ch_cnt - 1;
    if (comp_start) begin
      cp_cnt <= lat_c;
      if (cp_n < LOGN) cp_log[cp_n] <= comp_buf;
      cp_n <= cp_n + 1;
    end else if (cp_cnt != 0) cp_cnt <= cp_cnt - 1;
    if (log_clr) begin
      ch_n <= 0; cp_n <= 0; overlap <= 1'b0;
    end else if (ch_cnt != 0 && cp_cnt != 0) overlap <= 1'b1;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int md, input int n, input int lr, input int lc,
                          input int lw, input int ign_at);
    int cyc;
    int k;
    int sb_tot;
    int mism;
    logic [1:0] exp_ch [LOGN];
    lat_r = lr; lat_c = lc; lat_w = lw;
    k = 0;
    if (md == 0) begin
      for (int i = 0; i < n; i++) begin
        exp_ch[k] = 2'b00; k++;
        exp_ch[k] = 2'b10; k++;
      end
    end else begin
      exp_ch[k] = 2'b00; k++;
      if (n > 1) begin exp_ch[k] = 2'b01; k++; end
      for (int i = 0; i < n; i++) begin
        exp_ch[k] = {1'b1, i[0]}; k++;
        if (i + 2 < n) begin exp_ch[k] = {1'b0, i[0]}; k++; end
      end
    end
    sb_tot = n * (lr + lc + lw + 3);

    @(negedge clk);
    start = 1'b1; mode = md[0]; iters = n[IW-1:0]; log_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; log_clr = 1'b0; mode = ~md[0]; iters = 16'd9;
    cyc = 1;
    chk(busy == (n != 0), "R2 busy after start", busy, n != 0);
    while (!done && cyc < 5000) begin
      if (cyc == ign_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(cyc < 5000, "R10 watchdog", cyc, 0);
    chk(!busy, "R10 busy low at done", busy, 0);
    chk(int'(tot_cyc) + 1 == cyc, "R10 done one cycle after final write", cyc, tot_cyc + 1);
    chk(chan_cyc == CW'(n * (lr + lw)), "R9 channel busy count", chan_cyc, n * (lr + lw));
    chk(comp_cyc == CW'(n * lc), "R9 compute busy count", comp_cyc, n * lc);
    chk(ch_n == 2 * n, "R4 transfer count", ch_n, 2 * n);
    chk(cp_n == n, "R4 compute count", cp_n, n);
    mism = 0;
    for (int i = 0; i < 2 * n && i < LOGN; i++) if (ch_log[i] !== exp_ch[i]) mism++;
    for (int i = 0; i < n && i < LOGN; i++)
      if (cp_log[i] !== ((md != 0) ? i[0] : 1'b0)) mism++;
    if (md == 0) begin
      chk(mism == 0, "R3 serial order on buffer 0", mism, 0);
      chk(int'(tot_cyc) == sb_tot, "R3 serial run time", tot_cyc, sb_tot);
    end else begin
      chk(mism == 0, "R4 ping-pong order and buffers", mism, 0);
      if (n == 1) chk(int'(tot_cyc) == sb_tot, "R8 single iteration time", tot_cyc, sb_tot);
      else begin
        chk(int'(tot_cyc) < sb_tot, "R8 faster than serial", tot_cyc, sb_tot);
        chk(int'(tot_cyc) >= n * ((lr + lw > lc) ? lr + lw : lc), "R8 lower bound",
            tot_cyc, n * ((lr + lw > lc) ? lr + lw : lc));
        chk(overlap, "R8 channel and compute overlap", overlap, 1);
      end
    end
    @(negedge clk);
    chk(!done, "R10 done is one cycle", done, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(chan_cyc == CW'(n * (lr + lw)) && comp_cyc == CW'(n * lc) && tot_cyc == CW'(cyc - 1),
        "R9 counters frozen after run", tot_cyc, cyc - 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset idle", {busy, done}, 0);
    chk(!xfer_start && !comp_start, "R1 no starts in reset", {xfer_start, comp_start}, 0);
    chk(chan_cyc == 0 && comp_cyc == 0 && tot_cyc == 0, "R1 counters zero", tot_cyc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !xfer_start && !comp_start, "R1 idle after reset", busy, 0);

    for (int r = 0; r < NROWS; r++)
      run_case(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], 0);

    // R11: start pulse mid-run with other count and mode must not disturb the job
    run_case(0, 3, 2, 3, 2, 5);
    run_case(1, 4, 3, 3, 3, 7);

    // R12: zero iterations, after a run so the counter clear (R2) is visible
    @(negedge clk);
    start = 1'b1; mode = 1'b1; iters = '0; log_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; log_clr = 1'b0;
    chk(done && !busy, "R12 done next cycle", done, 1);
    chk(chan_cyc == 0 && comp_cyc == 0 && tot_cyc == 0, "R12 R2 counters cleared", tot_cyc, 0);
    @(negedge clk);
    chk(!done, "R12 single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(ch_n == 0 && cp_n == 0, "R12 nothing issued", ch_n + cp_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule